// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial two-wire slave that holds an 18-byte configuration register file for a board-level controller. A host on the bus can reach a single register with an indexed byte access. It can also move the whole file with a block access, which always starts at register 0 and climbs one offset per byte. SCL and SDA are sampled on the system clock through two-flop synchronisers. The block drives SDA only by pulling it low, which suits an open-drain pad.

The register contents are presented in parallel on a flat output vector. Each byte has a one-cycle write strobe, so downstream logic can react to host updates. Some fields are fixed:
- five bits of register 5 show the board strap inputs;
- the low nibble of register 6 holds a vendor code;
- bit 2 of register 9 is a status flag. An event input sets it, and the host clears it by writing a one.

Top module: `smbcfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 69h (D2h for a write, D3h for a read). A transfer to any other address gets no acknowledge and leaves every register unchanged.
- R2: After reset, registers 1, 2, 3, 8 and 15 hold FFh, 7Fh, EBh, 3Eh and 03h. Register 5 reads strap bits in [7:3] and zero elsewhere. Register 6 reads 08h. Every other register reads 00h.
- R3: A command byte with bit 7 set selects an indexed access, and bits 6:0 give the offset. The next data byte, received MSB first, is stored at that offset. The matching bit of `cfgWrStb` pulses for exactly one cycle, and at most one strobe bit is high in any cycle.
- R4: An indexed read (command, repeated START, address+R) returns the addressed register MSB first, as it appears on `cfgOut`.
- R5: A command byte of 00h selects a block write. The host sends a count byte, and data bytes then land at offsets 0, 1, 2 and upward. Every byte is acknowledged. Data bytes beyond the count are acknowledged and discarded.
- R6: A block read returns the count byte 18 first, then registers from offset 0 upward, for as long as the host acknowledges. Offsets of 18 and above return 00h.
- R7: A STOP after any whole byte ends the transfer. Bytes already acknowledged stay written.
- R8: A write to an offset of 18 or more is acknowledged and changes nothing. A read from such an offset returns 00h.
- R9: Register 5 bits [7:3] always show `strapIn`, and register 6 bits [3:0] always read 8h. Host writes cannot change these bits.
- R10: A one-cycle pulse on `timeoutEvt` sets register 9 bit 2 on the next cycle. Writing a 1 to that bit clears it, and writing a 0 leaves it set. The bit can only rise after a `timeoutEvt` pulse.
- R11: The slave changes its SDA drive only while the synchronised SCL is low, except when a START or STOP releases it. After a STOP the drive is released.
- R12: A START at any point, even in the middle of a byte, abandons the current transfer and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level from the pad |
| sdaIn | input | 1 | Bus data level from the pad |
| sdaDrvLow | output | 1 | 1 pulls SDA low; 0 releases it |
| strapIn | input | 5 | Board strap levels shown in register 5 bits [7:3] |
| timeoutEvt | input | 1 | Pulse that sets the status flag, register 9 bit 2 |
| cfgOut | output | 144 | Register file contents, byte i at bits [8i+7:8i] |
| cfgWrStb | output | 18 | One-cycle pulse per byte written by the host |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- SDA drive changes only while SCL is low, and the drive is released after a STOP;
- the write strobes are one-hot or idle;
- the vendor nibble never moves;
- the status flag is set after an event and rises only after one.

The bench has to build the protocol-level results from whole transactions, because they depend on bus sequencing:
- address filtering;
- count handling in block writes;
- the leading count byte and zero fill in block reads;
- early STOP;
- restart in the middle of a byte;
- write-one-to-clear.

The bench checks these against a behavioural register model. That model is compared with `cfgOut` on every clock while the bus is idle.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
  localparam int BYTE_W = 8;
  localparam int OFFS_W = 7;

  // write request from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic [OFFS_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } regStb_t;

  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK} phase_t;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_COUNT, K_DATA} kind_t;

  function automatic logic [BYTE_W-1:0] resetValue(input int idx);
    case (idx)
      1:       return 8'hFF;
      2:       return 8'h7F;
      3:       return 8'hEB;
      8:       return 8'h3E;
      15:      return 8'h03;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smbcfg_ctrl.sv
module smbcfg_ctrl
  import smbcfg_pkg::*;
#(
  parameter int               REG_COUNT  = 18,
  parameter logic [6:0]       SLAVE_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdData,
  output logic              sdaDrvLow,
  output logic [OFFS_W-1:0] rdPtr,
  output regStb_t           regStb
);
  localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(REG_COUNT);

  logic [1:0] sclSy, sdaSy;
  logic sclP, sdaP;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclSy <= 2'b11; sdaSy <= 2'b11; sclP <= 1'b1; sdaP <= 1'b1;
    end else begin
      sclSy <= {sclSy[0], sclIn};
      sdaSy <= {sdaSy[0], sdaIn};
      sclP  <= sclSy[1];
      sdaP  <= sdaSy[1];
    end

  logic sclS, sdaS, startC, stopC, sclRise, sclFall;
  assign sclS    = sclSy[1];
  assign sdaS    = sdaSy[1];
  assign startC  = sclS & sclP & sdaP & ~sdaS;
  assign stopC   = sclS & sclP & ~sdaP & sdaS;
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;

  phase_t            phase;
  kind_t             kind;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] shiftR, remain, rxByte, txByte;
  logic              rdDir, blockMode, cntPend;
  logic [OFFS_W-1:0] ptr;

  assign rxByte = {shiftR[BYTE_W-2:0], sdaS};
  assign txByte = cntPend ? COUNT_BYTE : rdData;
  assign rdPtr  = ptr;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      phase <= PH_IDLE; kind <= K_ADDR; bitCnt <= '0; shiftR <= '0;
      remain <= '0; rdDir <= 1'b0; blockMode <= 1'b0; cntPend <= 1'b0;
      ptr <= '0; sdaDrvLow <= 1'b0; regStb <= '0;
    end else begin
      regStb.wrEn <= 1'b0;
      if (startC) begin
        phase <= PH_RX; kind <= K_ADDR; bitCnt <= '0; sdaDrvLow <= 1'b0;
      end else if (stopC) begin
        phase <= PH_IDLE; sdaDrvLow <= 1'b0;
      end else begin
        case (phase)
          PH_RX: if (sclRise) begin
            shiftR <= rxByte;
            if (bitCnt == 4'd7) begin
              bitCnt <= 4'd8;
              phase  <= PH_RXACK;
              case (kind)
                K_ADDR:
                  if (rxByte[7:1] == SLAVE_ADDR) rdDir <= rxByte[0];
                  else phase <= PH_IDLE;
                K_CMD: begin
                  blockMode <= ~rxByte[7];
                  cntPend   <= ~rxByte[7];
                  ptr       <= rxByte[7] ? rxByte[OFFS_W-1:0] : '0;
                end
                K_COUNT: begin
                  remain  <= rxByte;
                  cntPend <= 1'b0;
                end
                default: begin
                  if (!blockMode || remain != '0) begin
                    regStb.wrEn <= 1'b1;
                    regStb.addr <= ptr;
                    regStb.data <= rxByte;
                  end
                  if (blockMode && remain != '0) remain <= remain - 1'b1;
                  ptr <= ptr + 1'b1;
                end
              endcase
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_RXACK: if (sclFall) begin
            if (bitCnt == 4'd8) begin
              sdaDrvLow <= 1'b1;
              bitCnt    <= 4'd9;
            end else begin
              sdaDrvLow <= 1'b0;
              bitCnt    <= '0;
              phase     <= PH_RX;
              case (kind)
                K_ADDR:
                  if (rdDir) begin
                    phase     <= PH_TX;
                    shiftR    <= txByte;
                    sdaDrvLow <= ~txByte[7];
                    cntPend   <= 1'b0;
                    if (!cntPend) ptr <= ptr + 1'b1;
                  end else begin
                    kind <= K_CMD;
                  end
                K_CMD:   kind <= blockMode ? K_COUNT : K_DATA;
                default: kind <= K_DATA;
              endcase
            end
          end
          PH_TX:
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaDrvLow <= 1'b0;
                phase     <= PH_TXACK;
              end else begin
                shiftR    <= {shiftR[BYTE_W-2:0], 1'b0};
                sdaDrvLow <= ~shiftR[BYTE_W-2];
              end
            end
          PH_TXACK:
            if (sclRise) begin
              if (sdaS) phase <= PH_IDLE;
              else bitCnt <= 4'd9;
            end else if (sclFall && bitCnt == 4'd9) begin
              phase     <= PH_TX;
              bitCnt    <= '0;
              shiftR    <= txByte;
              sdaDrvLow <= ~txByte[7];
              cntPend   <= 1'b0;
              if (!cntPend) ptr <= ptr + 1'b1;
            end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/smbcfg_regs.sv
module smbcfg_regs
  import smbcfg_pkg::*;
#(
  parameter int         REG_COUNT = 18,
  parameter logic [3:0] VENDOR_ID = 4'h8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  regStb_t                     regStb,
  input  logic                        timeoutEvt,
  input  logic [4:0]                  strapIn,
  input  logic [OFFS_W-1:0]           rdPtr,
  output logic [BYTE_W-1:0]           rdData,
  output logic [REG_COUNT*BYTE_W-1:0] cfgOut,
  output logic [REG_COUNT-1:0]        cfgWrStb
);
  localparam int STRAP_IDX = 5;
  localparam int VEND_IDX  = 6;
  localparam int STAT_IDX  = 9;

  logic [BYTE_W-1:0] viewArr [REG_COUNT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_byte
    localparam logic [BYTE_W-1:0] RO_MASK  = (i == STRAP_IDX) ? 8'hF8 :
                                             (i == VEND_IDX)  ? 8'h0F : 8'h00;
    localparam logic [BYTE_W-1:0] W1C_MASK = (i == STAT_IDX) ? 8'h04 : 8'h00;
    localparam logic [BYTE_W-1:0] NORM     = ~(RO_MASK | W1C_MASK);
    localparam logic [BYTE_W-1:0] RST      = resetValue(i) & ~RO_MASK;

    logic              hit, wrPulse;
    logic [BYTE_W-1:0] stored, roVal, w1cNext;

    assign hit     = regStb.wrEn && (regStb.addr == OFFS_W'(i));
    assign w1cNext = (stored & ~(hit ? regStb.data : '0)) | {BYTE_W{timeoutEvt}};
    assign roVal   = (i == STRAP_IDX) ? {strapIn, 3'b000} :
                     (i == VEND_IDX)  ? {4'h0, VENDOR_ID} : '0;

    always_ff @(posedge clk or negedge rstN)
      if (!rstN) begin
        stored  <= RST;
        wrPulse <= 1'b0;
      end else begin
        wrPulse <= hit;
        stored  <= ((hit ? regStb.data : stored) & NORM) | (w1cNext & W1C_MASK);
      end

    assign viewArr[i]                 = (stored & ~RO_MASK) | (roVal & RO_MASK);
    assign cfgOut[i*BYTE_W +: BYTE_W] = viewArr[i];
    assign cfgWrStb[i]                = wrPulse;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < REG_COUNT; i++)
      if (rdPtr == OFFS_W'(i)) rdData = viewArr[i];
  end
endmodule

// File: rtl/smbcfg_slave.sv
module smbcfg_slave
  import smbcfg_pkg::*;
#(
  parameter int         REG_COUNT  = 18,
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter logic [3:0] VENDOR_ID  = 4'h8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaDrvLow,
  input  logic [4:0]                  strapIn,
  input  logic                        timeoutEvt,
  output logic [REG_COUNT*BYTE_W-1:0] cfgOut,
  output logic [REG_COUNT-1:0]        cfgWrStb
);
  regStb_t           regStb;
  logic [OFFS_W-1:0] rdPtr;
  logic [BYTE_W-1:0] rdData;

  smbcfg_ctrl #(.REG_COUNT(REG_COUNT), .SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .rdData(rdData),
    .sdaDrvLow(sdaDrvLow), .rdPtr(rdPtr), .regStb(regStb)
  );

  smbcfg_regs #(.REG_COUNT(REG_COUNT), .VENDOR_ID(VENDOR_ID)) u_regs (
    .clk(clk), .rstN(rstN), .regStb(regStb), .timeoutEvt(timeoutEvt),
    .strapIn(strapIn), .rdPtr(rdPtr), .rdData(rdData), .cfgOut(cfgOut),
    .cfgWrStb(cfgWrStb)
  );
endmodule

// File: rtl/smbcfg_chk.sv
module smbcfg_chk #(
  parameter int         REG_COUNT = 18,
  parameter logic [3:0] VENDOR_ID = 4'h8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sclIn,
  input logic                 sdaIn,
  input logic                 sdaDrvLow,
  input logic                 timeoutEvt,
  input logic [3:0]           vendorNib,
  input logic                 statBit,
  input logic [REG_COUNT-1:0] cfgWrStb
);
  logic [1:0] cScl, cSda;
  logic cSclP, cSdaP;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      cScl <= 2'b11; cSda <= 2'b11; cSclP <= 1'b1; cSdaP <= 1'b1;
    end else begin
      cScl <= {cScl[0], sclIn}; cSda <= {cSda[0], sdaIn};
      cSclP <= cScl[1]; cSdaP <= cSda[1];
    end

  logic cBusEdge, cStop;
  assign cBusEdge = cScl[1] & cSclP & (cSdaP ^ cSda[1]);
  assign cStop    = cScl[1] & cSclP & ~cSdaP & cSda[1];

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((sdaDrvLow != $past(sdaDrvLow)) && !$past(cBusEdge)) |-> !$past(cScl[1]));

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    cStop |=> !sdaDrvLow);

  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cfgWrStb));

  assert_vendor_fixed_R9: assert property (@(posedge clk) disable iff (!rstN)
    $stable(vendorNib) && vendorNib == VENDOR_ID);

  assert_status_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutEvt |=> statBit);

  assert_status_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statBit) |-> $past(timeoutEvt));
endmodule

bind smbcfg_slave smbcfg_chk #(.REG_COUNT(REG_COUNT), .VENDOR_ID(VENDOR_ID)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaDrvLow(sdaDrvLow),
  .timeoutEvt(timeoutEvt), .vendorNib(cfgOut[6*8+3:6*8]), .statBit(cfgOut[9*8+2]),
  .cfgWrStb(cfgWrStb)
);

// File: tb/smbcfg_slave_tb.sv
module smbcfg_slave_tb;
  localparam int N = 18;
  localparam int Q = 10;

  logic clk = 1'b0, rstN = 1'b0, sclIn = 1'b1, mSdaLow = 1'b0, timeoutEvt = 1'b0;
  logic [4:0] strapIn = 5'b10110;
  logic sdaDrvLow, sdaLine;
  logic [N*8-1:0] cfgOut;
  logic [N-1:0] cfgWrStb;

  assign sdaLine = !(mSdaLow || sdaDrvLow);

  smbcfg_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaLine), .sdaDrvLow(sdaDrvLow),
    .strapIn(strapIn), .timeoutEvt(timeoutEvt), .cfgOut(cfgOut), .cfgWrStb(cfgWrStb)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  logic [7:0] mdl [N];
  int stbCnt [N];
  logic idleCmp = 1'b0;
  string curReq = "R2";

  function automatic logic [7:0] view(int i);
    if (i >= N) return 8'h00;
    if (i == 5) return (mdl[5] & 8'h07) | {strapIn, 3'b000};
    if (i == 6) return (mdl[6] & 8'hF0) | 8'h08;
    return mdl[i];
  endfunction

  function automatic void mdlWrite(int i, logic [7:0] d);
    if (i >= N) return;
    if (i == 5) mdl[5] = d & 8'h07;
    else if (i == 6) mdl[6] = d & 8'hF0;
    else if (i == 9) mdl[9] = (d & 8'hFB) | (mdl[9] & 8'h04 & ~d);
    else mdl[i] = d;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model while the bus is idle
  always @(negedge clk) if (rstN) begin
    for (int i = 0; i < N; i++) if (cfgWrStb[i]) stbCnt[i]++;
    if (idleCmp) begin
      int bad = -1;
      for (int i = 0; i < N; i++) if (cfgOut[i*8 +: 8] != view(i)) bad = i;
      if (bad >= 0) check(curReq, $sformatf("cfg byte %0d", bad), int'(cfgOut[bad*8 +: 8]), int'(view(bad)));
      else checks++;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic busStart();
    mSdaLow = 1'b0; tick(Q); sclIn = 1'b1; tick(Q);
    mSdaLow = 1'b1; tick(Q); sclIn = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; tick(Q); sclIn = 1'b1; tick(Q); mSdaLow = 1'b0; tick(2*Q);
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int k = 0; k < n; k++) begin
      mSdaLow = !b[7-k]; tick(Q); sclIn = 1'b1; tick(2*Q); sclIn = 1'b0; tick(Q);
    end
  endtask

  task automatic sendByte(logic [7:0] b, output logic ackd);
    sendBits(b, 8);
    mSdaLow = 1'b0; tick(Q); sclIn = 1'b1; tick(Q);
    ackd = !sdaLine; tick(Q); sclIn = 1'b0; tick(Q);
  endtask

  task automatic recvByte(logic mAck, output logic [7:0] b);
    mSdaLow = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick(Q); sclIn = 1'b1; tick(Q); b = {b[6:0], sdaLine}; tick(Q); sclIn = 1'b0;
    end
    tick(Q); mSdaLow = mAck; tick(Q); sclIn = 1'b1; tick(2*Q); sclIn = 1'b0; tick(Q);
    mSdaLow = 1'b0;
  endtask

  task automatic wrByte(int off, logic [7:0] d, string req);
    logic a;
    idleCmp = 1'b0; curReq = req;
    busStart();
    sendByte(8'hD2, a); check("R1", "addr ack", a, 1);
    sendByte({1'b1, 7'(off)}, a); check(req, "cmd ack", a, 1);
    sendByte(d, a); check(req, "data ack", a, 1);
    busStop();
    mdlWrite(off, d); idleCmp = 1'b1; tick(4);
  endtask

  task automatic rdByte(int off, string req);
    logic a; logic [7:0] b;
    idleCmp = 1'b0; curReq = req;
    busStart();
    sendByte(8'hD2, a); sendByte({1'b1, 7'(off)}, a);
    busStart();
    sendByte(8'hD3, a); check("R1", "read addr ack", a, 1);
    recvByte(1'b0, b);
    busStop();
    check(req, $sformatf("read off %0d", off), b, view(off));
    idleCmp = 1'b1; tick(4);
  endtask

  task automatic blkWrite(int cnt, logic [7:0] data [$], string req);
    logic a;
    idleCmp = 1'b0; curReq = req;
    busStart();
    sendByte(8'hD2, a); sendByte(8'h00, a); check(req, "block cmd ack", a, 1);
    sendByte(8'(cnt), a); check(req, "count ack", a, 1);
    foreach (data[k]) begin
      sendByte(data[k], a); check(req, $sformatf("block data %0d ack", k), a, 1);
    end
    busStop();
    foreach (data[k]) if (k < cnt) mdlWrite(k, data[k]);
    idleCmp = 1'b1; tick(4);
  endtask

  task automatic blkRead(int n, string req);
    logic a; logic [7:0] b;
    idleCmp = 1'b0; curReq = req;
    busStart();
    sendByte(8'hD2, a); sendByte(8'h00, a);
    busStart();
    sendByte(8'hD3, a);
    recvByte(n > 0, b); check(req, "count byte", b, N);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b); check(req, $sformatf("block byte %0d", k), b, view(k));
    end
    busStop();
    idleCmp = 1'b1; tick(4);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check("R1", "watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin : main
    logic a; int s0;
    for (int i = 0; i < N; i++) begin mdl[i] = 8'h00; stbCnt[i] = 0; end
    mdl[1] = 8'hFF; mdl[2] = 8'h7F; mdl[3] = 8'hEB; mdl[8] = 8'h3E; mdl[15] = 8'h03;
    tick(5); rstN = 1'b1; tick(2);
    check("R11", "reset sda release", sdaDrvLow, 0);
    for (int i = 0; i < N; i++) check("R2", $sformatf("reset byte %0d", i), cfgOut[i*8 +: 8], view(i));
    idleCmp = 1'b1;

    // R3 / R4 indexed write and read, strobe count
    s0 = stbCnt[1];
    wrByte(1, 8'h5A, "R3");
    check("R3", "strobe pulses byte1", stbCnt[1] - s0, 1);
    rdByte(1, "R4");
    rdByte(3, "R4");

    // R9 read-only fields
    wrByte(5, 8'hFF, "R9"); rdByte(5, "R9");
    wrByte(6, 8'hA5, "R9"); rdByte(6, "R9");

    // R10 write-one-to-clear status
    idleCmp = 1'b0; timeoutEvt = 1'b1; tick(1); timeoutEvt = 1'b0; tick(2);
    mdl[9] = mdl[9] | 8'h04; idleCmp = 1'b1; curReq = "R10";
    rdByte(9, "R10");
    wrByte(9, 8'h00, "R10"); rdByte(9, "R10");
    wrByte(9, 8'h84, "R10"); rdByte(9, "R10");

    // R8 out-of-range offset
    s0 = 0; for (int i = 0; i < N; i++) s0 += stbCnt[i];
    wrByte(20, 8'h77, "R8");
    begin int s1 = 0; for (int i = 0; i < N; i++) s1 += stbCnt[i];
      check("R8", "strobes for offset 20", s1 - s0, 0); end
    rdByte(20, "R8");

    // R5 block write with extra byte beyond count
    blkWrite(3, '{8'h11, 8'h22, 8'h33, 8'h44}, "R5");
    rdByte(3, "R5");

    // R7 early stop inside a block write
    blkWrite(5, '{8'h91, 8'h92}, "R7");
    rdByte(2, "R7");

    // R6 block reads, including past the end
    blkRead(5, "R6");
    blkRead(20, "R6");

    // R1 foreign address ignored
    idleCmp = 1'b0; curReq = "R1";
    busStart();
    sendByte(8'hA0, a); check("R1", "foreign addr nack", a, 0);
    sendByte(8'h81, a); sendByte(8'h00, a);
    busStop(); idleCmp = 1'b1; tick(4);
    rdByte(1, "R1");

    // R12 START in the middle of a command byte
    idleCmp = 1'b0; curReq = "R12";
    busStart();
    sendByte(8'hD2, a);
    sendBits(8'h81, 3);
    busStart();
    sendByte(8'hD2, a); check("R12", "addr ack after restart", a, 1);
    sendByte(8'h81, a); sendByte(8'h3C, a);
    busStop(); mdlWrite(1, 8'h3C); idleCmp = 1'b1; tick(4);
    rdByte(1, "R12");

    check("R11", "sda released at end", sdaDrvLow, 0);
    tick(20);
    summary();
    $finish;
  end
endmodule